// File: doc/BRIEF.md
# Instrument Status Byte and Service-Request Logic

This block keeps the event and summary state that an instrument reports to its controller. An 8-bit event register collects sticky error and completion flags. A write/read enable mask picks which of those flags count towards a one-bit event summary. That summary, a message-available flag taken from the output queue, and a request bit make up a status byte. A second mask, the service-request enable, selects which status bits produce the master summary. On each rising edge of the master summary a request bit is latched, and that bit drives the service-request line.

Bit 6 of the status byte reads differently depending on how it is read. A status-byte query returns the live master summary and clears nothing. A serial poll returns the latched request bit and clears only that bit. A clear-status strobe empties the event register. If that strobe is the first command after a program message terminator, the block also sends a pulse that flushes the output queue. Command parsing, the queue and the bus handshake are outside this block.

Top module: `srq_status`

## Requirements
- R1: After reset the event register reads 0x80 (power-on bit only), both enable masks read 0x00, the service-request line is 0 and queueFlush is 0.
- R2: Each event pulse sets its event register bit on the next clock edge, and the bit stays set until it is cleared. The mapping is: power-on to bit 7, command error to bit 5, execution error to bit 4, device error to bit 3, query error to bit 2, operation complete to bit 0. Bits 6 and 1 always read 0.
- R3: Status bit 5 is 1 when any bit of the event register is 1 in the same position as a 1 in the event enable mask.
- R4: Status bit 4 equals queueNotEmpty. Status bits 7 and 3 to 0 always read 0.
- R5: While stbQuery is high or no poll is in progress, status bit 6 carries the master summary, (bit5 AND sre[5]) OR (bit4 AND sre[4]). A query clears no state.
- R6: The request bit is set on the clock edge after the one at which the master summary goes from 0 to 1. srqOut always equals the request bit.
- R7: While serialPoll is high, status bit 6 shows the request bit. On the next edge the request bit is cleared, unless the master summary rises on that same edge. A poll changes no other register.
- R8: clearStatus empties the event register on the next edge. Event pulses in the same cycle are still recorded. MAV is not affected.
- R9: queueFlush is high in the same cycle as clearStatus only if msgTerm was seen in an earlier cycle and no command strobe (clearStatus, esrRead, eseWrite, sreWrite, stbQuery) came between. msgTerm re-arms the flush even when it arrives together with a command strobe.
- R10: esrData always shows the event register. esrRead clears the register on the next edge, and event pulses in the same cycle are still recorded.
- R11: eseWrite loads eseWrData and sreWrite loads sreWrData, each on the next edge, and both read back on eseData and sreData. Bit 6 of the service-request enable always reads 0 and takes no part in the summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evPowerOn | input | 1 | Power-on event pulse |
| evCmdErr | input | 1 | Command error pulse |
| evExecErr | input | 1 | Execution error pulse |
| evDevErr | input | 1 | Device error pulse |
| evQueryErr | input | 1 | Query error pulse |
| evOpDone | input | 1 | Operation complete pulse |
| eseWrite | input | 1 | Event enable write strobe |
| eseWrData | input | 8 | Event enable write data |
| sreWrite | input | 1 | Service-request enable write strobe |
| sreWrData | input | 8 | Service-request enable write data |
| esrRead | input | 1 | Event register read strobe (read and clear) |
| stbQuery | input | 1 | Status byte query strobe |
| serialPoll | input | 1 | Serial poll strobe |
| clearStatus | input | 1 | Clear-status strobe |
| msgTerm | input | 1 | Program message terminator seen |
| queueNotEmpty | input | 1 | Output queue holds data |
| esrData | output | 8 | Event register contents |
| eseData | output | 8 | Event enable mask |
| sreData | output | 8 | Service-request enable mask |
| stbData | output | 8 | Status byte read data |
| srqOut | output | 1 | Service-request line |
| queueFlush | output | 1 | Output queue flush pulse |

## Verification
The assertions assume that serialPoll and stbQuery are never high in the same cycle. They also assume that strobes and event pulses are single-cycle levels sampled at the clock edge. The random stimulus meets the first assumption by choosing at most one of the two read kinds in each cycle. Strobe and event probabilities are kept low so that the request bit can rise, be polled, and rise again. Directed runs cover three cases: a poll that lands on the same edge as a new summary rise, clear-status together with an event pulse, and the terminator arriving together with a command strobe.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int unsigned ByteW   = 8;
  // event register bit positions
  localparam int unsigned EvPon   = 7;
  localparam int unsigned EvUrq   = 6;
  localparam int unsigned EvCme   = 5;
  localparam int unsigned EvExe   = 4;
  localparam int unsigned EvDde   = 3;
  localparam int unsigned EvQye   = 2;
  localparam int unsigned EvRqc   = 1;
  localparam int unsigned EvOpc   = 0;
  // status byte bit positions
  localparam int unsigned StMss   = 6;
  localparam int unsigned StEsb   = 5;
  localparam int unsigned StMav   = 4;
  localparam logic [ByteW-1:0] EvLiveMask = ~((ByteW'(1) << EvUrq) | (ByteW'(1) << EvRqc));
  localparam logic [ByteW-1:0] SreLiveMask = ~(ByteW'(1) << StMss);
  localparam logic [ByteW-1:0] EvResetVal = ByteW'(1) << EvPon;

  typedef struct packed {
    logic clrEvents;
    logic wrEse;
    logic wrSre;
  } strobes_t;
endpackage

// File: rtl/srq_dpath.sv
module srq_dpath
  import srq_pkg::*;
#(
  parameter int unsigned W = ByteW
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobes_t     stb,
  input  logic [W-1:0] evPulse,
  input  logic [W-1:0] eseWrData,
  input  logic [W-1:0] sreWrData,
  input  logic         mav,
  output logic [W-1:0] esrQ,
  output logic [W-1:0] eseQ,
  output logic [W-1:0] sreQ,
  output logic         esb,
  output logic         mss
);
  logic [W-1:0] esrNext;

  always_comb begin
    esrNext = stb.clrEvents ? '0 : esrQ;
    esrNext = (esrNext | evPulse) & EvLiveMask[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      esrQ <= EvResetVal[W-1:0];
      eseQ <= '0;
      sreQ <= '0;
    end else begin
      esrQ <= esrNext;
      if (stb.wrEse) eseQ <= eseWrData;
      if (stb.wrSre) sreQ <= sreWrData & SreLiveMask[W-1:0];
    end
  end

  assign esb = |(esrQ & eseQ);
  assign mss = (esb & sreQ[StEsb]) | (mav & sreQ[StMav]);

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrEvents && evPulse == '0) |=> esrQ == '0);
  // R2
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clrEvents) |=> ((esrQ & $past(esrQ)) == $past(esrQ)));
  // R11
  ese_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEse |=> eseQ == $past(eseWrData));
endmodule

// File: rtl/srq_ctrl.sv
module srq_ctrl
  import srq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     eseWrite,
  input  logic     sreWrite,
  input  logic     esrRead,
  input  logic     stbQuery,
  input  logic     serialPoll,
  input  logic     clearStatus,
  input  logic     msgTerm,
  input  logic     mss,
  output strobes_t stb,
  output logic     rqs,
  output logic     queueFlush
);
  logic mssQ;
  logic termArmed;
  logic anyCmd;
  logic mssRise;

  assign anyCmd  = clearStatus | esrRead | eseWrite | sreWrite | stbQuery;
  assign mssRise = mss & ~mssQ;

  assign stb.clrEvents = clearStatus | esrRead;
  assign stb.wrEse     = eseWrite;
  assign stb.wrSre     = sreWrite;
  assign queueFlush    = clearStatus & termArmed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mssQ      <= 1'b0;
      rqs       <= 1'b0;
      termArmed <= 1'b0;
    end else begin
      mssQ <= mss;
      if (mssRise)         rqs <= 1'b1;
      else if (serialPoll) rqs <= 1'b0;
      if (msgTerm)         termArmed <= 1'b1;
      else if (anyCmd)     termArmed <= 1'b0;
    end
  end

  // R6
  rqs_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mss) |=> rqs);
  // R7
  poll_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serialPoll && !$rose(mss)) |=> !rqs);
  // R9
  flush_needs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueFlush |-> clearStatus);
  // R6
  rqs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rqs && !serialPoll) |=> rqs);
endmodule

// File: rtl/srq_status.sv
module srq_status
  import srq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evPowerOn,
  input  logic       evCmdErr,
  input  logic       evExecErr,
  input  logic       evDevErr,
  input  logic       evQueryErr,
  input  logic       evOpDone,
  input  logic       eseWrite,
  input  logic [7:0] eseWrData,
  input  logic       sreWrite,
  input  logic [7:0] sreWrData,
  input  logic       esrRead,
  input  logic       stbQuery,
  input  logic       serialPoll,
  input  logic       clearStatus,
  input  logic       msgTerm,
  input  logic       queueNotEmpty,
  output logic [7:0] esrData,
  output logic [7:0] eseData,
  output logic [7:0] sreData,
  output logic [7:0] stbData,
  output logic       srqOut,
  output logic       queueFlush
);
  strobes_t         stb;
  logic [ByteW-1:0] evPulse;
  logic             esb;
  logic             mss;
  logic             rqs;

  always_comb begin
    evPulse        = '0;
    evPulse[EvPon] = evPowerOn;
    evPulse[EvCme] = evCmdErr;
    evPulse[EvExe] = evExecErr;
    evPulse[EvDde] = evDevErr;
    evPulse[EvQye] = evQueryErr;
    evPulse[EvOpc] = evOpDone;
  end

  srq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .eseWrite(eseWrite), .sreWrite(sreWrite),
    .esrRead(esrRead), .stbQuery(stbQuery), .serialPoll(serialPoll),
    .clearStatus(clearStatus), .msgTerm(msgTerm), .mss(mss),
    .stb(stb), .rqs(rqs), .queueFlush(queueFlush)
  );

  srq_dpath #(.W(ByteW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .evPulse(evPulse),
    .eseWrData(eseWrData), .sreWrData(sreWrData), .mav(queueNotEmpty),
    .esrQ(esrData), .eseQ(eseData), .sreQ(sreData), .esb(esb), .mss(mss)
  );

  always_comb begin
    stbData         = '0;
    stbData[StEsb]  = esb;
    stbData[StMav]  = queueNotEmpty;
    stbData[StMss]  = serialPoll ? rqs : mss;
  end

  assign srqOut = rqs;

  // R5
  no_dual_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(serialPoll && stbQuery));
  // R4
  mav_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stbData[StMav] == queueNotEmpty) && (stbData[7] == 1'b0) && (stbData[3:0] == 4'h0));
  // R2
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    esrData[EvUrq] == 1'b0 && esrData[EvRqc] == 1'b0);
endmodule

// File: tb/test_srq_status.sv
module test_srq_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evPowerOn = 0, evCmdErr = 0, evExecErr = 0, evDevErr = 0, evQueryErr = 0, evOpDone = 0;
  logic eseWrite = 0, sreWrite = 0, esrRead = 0, stbQuery = 0, serialPoll = 0;
  logic clearStatus = 0, msgTerm = 0, queueNotEmpty = 0;
  logic [7:0] eseWrData = 0, sreWrData = 0;
  logic [7:0] esrData, eseData, sreData, stbData;
  logic srqOut, queueFlush;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  logic [7:0] mEsr, mEse, mSre;
  logic mMssQ, mRqs, mArmed;

  always #2 clk = ~clk;

  srq_status i_srq_status (
    .clk(clk), .rstN(rstN), .evPowerOn(evPowerOn), .evCmdErr(evCmdErr),
    .evExecErr(evExecErr), .evDevErr(evDevErr), .evQueryErr(evQueryErr),
    .evOpDone(evOpDone), .eseWrite(eseWrite), .eseWrData(eseWrData),
    .sreWrite(sreWrite), .sreWrData(sreWrData), .esrRead(esrRead),
    .stbQuery(stbQuery), .serialPoll(serialPoll), .clearStatus(clearStatus),
    .msgTerm(msgTerm), .queueNotEmpty(queueNotEmpty), .esrData(esrData),
    .eseData(eseData), .sreData(sreData), .stbData(stbData), .srqOut(srqOut),
    .queueFlush(queueFlush)
  );

  function automatic logic [7:0] evVec();
    return {evPowerOn, 1'b0, evCmdErr, evExecErr, evDevErr, evQueryErr, 1'b0, evOpDone};
  endfunction

  function automatic logic expMss();
    logic esb = |(mEsr & mEse);
    return (esb & mSre[5]) | (queueNotEmpty & mSre[4]);
  endfunction

  function automatic logic [7:0] expStb();
    logic [7:0] s = 8'h00;
    s[5] = |(mEsr & mEse);
    s[4] = queueNotEmpty;
    s[6] = serialPoll ? mRqs : expMss();
    return s;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic clearIns();
    {evPowerOn, evCmdErr, evExecErr, evDevErr, evQueryErr, evOpDone} = '0;
    {eseWrite, sreWrite, esrRead, stbQuery, serialPoll, clearStatus, msgTerm} = '0;
  endtask

  // check outputs against model, then advance the model across the edge
  task automatic stepCheck();
    logic mss;
    logic cmd;
    #1;
    chk("R2/R10 esrData", esrData, mEsr);
    chk("R11 eseData", eseData, mEse);
    chk("R11 sreData", sreData, mSre);
    chk(serialPoll ? "R7 stbData" : "R3/R4/R5 stbData", stbData, expStb());
    chk("R6 srqOut", {7'h0, srqOut}, {7'h0, mRqs});
    chk("R9 queueFlush", {7'h0, queueFlush}, {7'h0, clearStatus & mArmed});
    mss = expMss();
    cmd = clearStatus | esrRead | eseWrite | sreWrite | stbQuery;
    @(posedge clk);
    mEsr = (((clearStatus | esrRead) ? 8'h00 : mEsr) | evVec()) & 8'hBD;
    if (eseWrite) mEse = eseWrData;
    if (sreWrite) mSre = sreWrData & 8'hBF;
    if (mss && !mMssQ) mRqs = 1'b1;
    else if (serialPoll) mRqs = 1'b0;
    mMssQ = mss;
    if (msgTerm) mArmed = 1'b1;
    else if (cmd) mArmed = 1'b0;
    @(negedge clk);
    clearIns();
  endtask

  initial begin
    #(4 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mEsr = 8'h80; mEse = 0; mSre = 0; mMssQ = 0; mRqs = 0; mArmed = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1;
    chk("R1 esrData", esrData, 8'h80);
    chk("R1 eseData", eseData, 8'h00);
    chk("R1 sreData", sreData, 8'h00);
    chk("R1 srqOut", {7'h0, srqOut}, 8'h00);
    chk("R1 queueFlush", {7'h0, queueFlush}, 8'h00);
    @(negedge clk);

    // R11 write enables, bit 6 of sre forced low
    eseWrite = 1; eseWrData = 8'hFF; stepCheck();
    sreWrite = 1; sreWrData = 8'hFF; stepCheck();
    stepCheck();
    // R6 summary already high from PON via ESB; poll to clear
    serialPoll = 1; stepCheck();
    stepCheck();
    // R8 clear with simultaneous event survives
    clearStatus = 1; evCmdErr = 1; stepCheck();
    stepCheck();
    // R10 read-clear
    esrRead = 1; stepCheck();
    stepCheck();
    // R9 armed flush, then terminator with command re-arms
    msgTerm = 1; stepCheck();
    clearStatus = 1; stepCheck();
    clearStatus = 1; stepCheck();
    msgTerm = 1; stbQuery = 1; stepCheck();
    clearStatus = 1; stepCheck();
    // R7 poll same edge as rising summary
    queueNotEmpty = 1; serialPoll = 1; stepCheck();
    stepCheck();
    queueNotEmpty = 0; stepCheck();
    // R2 each event individually
    evPowerOn = 1; stepCheck();
    evExecErr = 1; stepCheck();
    evDevErr = 1; stepCheck();
    evQueryErr = 1; stepCheck();
    evOpDone = 1; stepCheck();
    stepCheck();

    for (int i = 0; i < 3000; i++) begin
      int r;
      if ($urandom_range(0, 9) == 0) queueNotEmpty = ~queueNotEmpty;
      evPowerOn  = ($urandom_range(0, 40) == 0);
      evCmdErr   = ($urandom_range(0, 15) == 0);
      evExecErr  = ($urandom_range(0, 15) == 0);
      evDevErr   = ($urandom_range(0, 15) == 0);
      evQueryErr = ($urandom_range(0, 15) == 0);
      evOpDone   = ($urandom_range(0, 15) == 0);
      r = $urandom_range(0, 19);
      if (r == 0) stbQuery = 1;
      else if (r < 4) serialPoll = 1;
      eseWrite    = ($urandom_range(0, 25) == 0);
      eseWrData   = 8'($urandom);
      sreWrite    = ($urandom_range(0, 25) == 0);
      sreWrData   = 8'($urandom);
      esrRead     = ($urandom_range(0, 20) == 0);
      clearStatus = ($urandom_range(0, 20) == 0);
      msgTerm     = ($urandom_range(0, 8) == 0);
      stepCheck();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule